// File: doc/BRIEF.md
# Shared-Ramp Conversion and Storage Sequencer

This block is the digital back end of a multi-channel front end that digitises charge and time by the ramp-comparison (Wilkinson) method. Each event is held in one column of a multi-column analog memory. For each column that holds at least one hit, the sequencer starts a charge ramp and then a time ramp. During each ramp one free-running Gray-coded counter is shared by every channel. Each channel keeps the count present in the cycle its end-of-ramp comparator first rises. If a comparator never fires, the channel keeps the full-scale value.

After both ramps of a column, the block writes one word per channel to on-chip RAM and then a column trailer. A channel word holds the hit flag, the latched gain flag, the charge code and the time code. The trailer holds the chip identifier, the column's crossing identifier and the column index. A conversion-done pulse ends the run. A no-trigger flag reports a run that found no hit at all, and a RAM-full flag reports that the RAM ran out of space.

Top module: `wilk_conv_seq`

## Requirements
- R1: After reset, ramp_run, ramp_time, wr_en, conv_done, no_trig and ram_full are all 0.
- R2: A start_conv pulse while idle walks the columns in index order 0..DEPTH-1. A column with no bit set in its slice hit_map[c*NCH +: NCH] is skipped with no ramp and no write.
- R3: Each converted column runs a charge ramp (ramp_run=1, ramp_time=0) and then a time ramp (ramp_run=1, ramp_time=1), each 2^CW cycles long. The shared count is 0 in the first ramp cycle and rises by one each cycle. A channel's stored code is the binary value of the count in the cycle its ramp_end bit is sampled high after being low (or high in the first ramp cycle).
- R4: Only the first rising edge of a channel's comparator in a ramp is kept; later edges in the same ramp are ignored.
- R5: A channel whose comparator has not risen by the last ramp cycle stores 2^CW-1.
- R6: Each channel's gain flag is the gain_sel bit sampled in the first cycle of the charge ramp. Changes on gain_sel afterwards have no effect on that column.
- R7: Per converted column, channel words are written for channels 0..NCH-1 in order: bit 2*CW+1 = hit flag of that channel in that column, bit 2*CW = gain flag, bits [2*CW-1:CW] = charge code, bits [CW-1:0] = time code, upper bits 0.
- R8: After the channel words of a column comes one trailer word {chip_id[7:0], crossing id of the column (BCW bits), column index (CIW bits)}, zero-extended to DW.
- R9: wr_addr starts at 0 for each run and rises by one per write. The write to address RAM_WORDS-1 sets ram_full. While ram_full is set no further writes occur, and it stays set until the next run starts.
- R10: conv_done is a one-cycle pulse after the last column has been handled. no_trig is 1 from that pulse until the next start if no column held a hit, and 0 otherwise.
- R11: A start_conv pulse during a run is ignored; the run's output is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_conv | input | 1 | Start a conversion run (pulse) |
| ramp_end | input | NCH | End-of-ramp comparator per channel |
| gain_sel | input | NCH | Gain path used per channel (1 = high gain) |
| hit_map | input | DEPTH*NCH | Hit flags, column c in bits [c*NCH +: NCH] |
| col_bcid | input | DEPTH*BCW | Crossing identifier per column |
| chip_id | input | 8 | Chip identifier |
| ramp_run | output | 1 | Analog ramp running |
| ramp_time | output | 1 | 0 = charge ramp, 1 = time ramp |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | AW | RAM write address |
| wr_data | output | DW | RAM write data |
| conv_done | output | 1 | Run finished (one cycle) |
| no_trig | output | 1 | Finished run contained no hit |
| ram_full | output | 1 | RAM space exhausted |

## Verification
The bench builds the block with four channels, four columns, a 4-bit counter, 4-bit crossing identifiers and a sixteen-word RAM. With these values each ramp lasts only sixteen cycles, so comparator edges at count 0, at full scale and never are all cheap to hit in every run. A run with every column hit produces twenty words, which overruns the RAM and exercises the full flag and write suppression. Random comparator times, hit maps and gain flags are mixed with these directed cases. A double edge on every comparator exercises the first-edge rule.

// File: rtl/wilk_conv_seq.sv
module wilk_conv_seq #(
  parameter int NCH       = 36,
  parameter int DEPTH     = 16,
  parameter int CW        = 12,
  parameter int BCW       = 8,
  parameter int RAM_WORDS = 2048,
  localparam int CIW = $clog2(DEPTH),
  localparam int AW  = $clog2(RAM_WORDS),
  localparam int IW  = $clog2(NCH + 1),
  localparam int CHI = $clog2(NCH),
  localparam int CHW = 2 + 2 * CW,
  localparam int TRW = 8 + BCW + CIW,
  localparam int DW  = (CHW > TRW) ? CHW : TRW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_conv,
  input  logic [NCH-1:0]         ramp_end,
  input  logic [NCH-1:0]         gain_sel,
  input  logic [DEPTH*NCH-1:0]   hit_map,
  input  logic [DEPTH*BCW-1:0]   col_bcid,
  input  logic [7:0]             chip_id,
  output logic                   ramp_run,
  output logic                   ramp_time,
  output logic                   wr_en,
  output logic [AW-1:0]          wr_addr,
  output logic [DW-1:0]          wr_data,
  output logic                   conv_done,
  output logic                   no_trig,
  output logic                   ram_full
);

  typedef enum logic [2:0] {S_IDLE, S_SEEK, S_RQ, S_RT, S_WR, S_DONE} st_t;

  st_t              st;
  logic [CIW-1:0]   col;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    idx;
  logic [AW-1:0]    addr;
  logic             full, any_hit, notrig;
  logic [CW-1:0]    q_g [NCH];
  logic [CW-1:0]    t_g [NCH];
  logic [NCH-1:0]   gain_q, cap, prev, fire, col_hits;
  logic [CHI-1:0]   ci;
  logic [CW-1:0]    gray;
  logic             last, col_last, trl;

  function automatic logic [CW-1:0] g2b(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int k = CW - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  assign col_hits = hit_map[col*NCH +: NCH];
  assign gray     = cnt ^ (cnt >> 1);
  assign last     = &cnt;
  assign col_last = (col == CIW'(DEPTH - 1));
  assign fire     = ramp_end & ~prev & ~cap;
  assign trl      = (idx == IW'(NCH));
  assign ci       = trl ? '0 : idx[CHI-1:0];

  assign ramp_run  = (st == S_RQ) || (st == S_RT);
  assign ramp_time = (st == S_RT);
  assign wr_en     = (st == S_WR) && !full;
  assign wr_addr   = addr;
  assign conv_done = (st == S_DONE);
  assign no_trig   = notrig;
  assign ram_full  = full;
  assign wr_data   = trl ? DW'({chip_id, col_bcid[col*BCW +: BCW], col})
                         : DW'({col_hits[ci], gain_q[ci], g2b(q_g[ci]), g2b(t_g[ci])});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; col <= '0; cnt <= '0; idx <= '0; addr <= '0;
      full <= 1'b0; any_hit <= 1'b0; notrig <= 1'b0;
      gain_q <= '0; cap <= '0; prev <= '0;
      for (int i = 0; i < NCH; i++) begin
        q_g[i] <= '0;
        t_g[i] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (start_conv) begin
          col <= '0; addr <= '0; full <= 1'b0; any_hit <= 1'b0; notrig <= 1'b0;
          st <= S_SEEK;
        end
        S_SEEK: begin
          if (|col_hits) begin
            st <= S_RQ; cnt <= '0; cap <= '0; prev <= '0; any_hit <= 1'b1;
          end else if (col_last) begin
            st <= S_DONE; notrig <= !any_hit;
          end else begin
            col <= col + 1'b1;
          end
        end
        S_RQ, S_RT: begin
          cnt  <= cnt + 1'b1;
          prev <= ramp_end;
          if (st == S_RQ && cnt == '0) gain_q <= gain_sel;
          for (int i = 0; i < NCH; i++) begin
            if (fire[i] || (last && !cap[i])) begin
              cap[i] <= 1'b1;
              if (st == S_RQ) q_g[i] <= gray;
              else            t_g[i] <= gray;
            end
          end
          if (last) begin
            if (st == S_RQ) begin
              st <= S_RT; cap <= '0; prev <= '0;
            end else begin
              st <= S_WR; idx <= '0;
            end
          end
        end
        S_WR: begin
          if (!full) begin
            addr <= addr + 1'b1;
            if (addr == AW'(RAM_WORDS - 1)) full <= 1'b1;
          end
          idx <= idx + 1'b1;
          if (trl) begin
            if (col_last) begin
              st <= S_DONE; notrig <= !any_hit;
            end else begin
              col <= col + 1'b1; st <= S_SEEK;
            end
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wilk_conv_seq_chk.sv
module wilk_conv_seq_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_conv,
  input logic          ramp_run,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          conv_done,
  input logic          no_trig,
  input logic          ram_full
);

  a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_addr == AW'($past(wr_addr) + 1'b1));

  a_r9_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ram_full |-> !wr_en);

  a_r9_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ram_full && !start_conv |=> ram_full);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> !ramp_run && !wr_en);

  a_r10_notrig_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    no_trig |-> !wr_en && !ramp_run);

  a_r3_ramp_vs_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !ramp_run);

endmodule

bind wilk_conv_seq wilk_conv_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_conv(start_conv), .ramp_run(ramp_run),
  .wr_en(wr_en), .wr_addr(wr_addr), .conv_done(conv_done),
  .no_trig(no_trig), .ram_full(ram_full)
);

// File: tb/tb_wilk_conv_seq.sv
module tb_wilk_conv_seq;
  localparam int NCH = 4, DEPTH = 4, CW = 4, BCW = 4, RW = 16;
  localparam int MAXV = (1 << CW) - 1;
  localparam int DW = 14, AW = 4;

  logic clk = 1'b0, rst_n = 1'b0, st_task = 1'b0, st_extra = 1'b0;
  wire  start_conv = st_task | st_extra;
  logic [NCH-1:0] ramp_end = '0, gain_sel = '0;
  logic [DEPTH*NCH-1:0] hit_map = '0;
  logic [DEPTH*BCW-1:0] col_bcid = '0;
  logic [7:0] chip_id = '0;
  wire ramp_run, ramp_time, wr_en, conv_done, no_trig, ram_full;
  wire [AW-1:0] wr_addr;
  wire [DW-1:0] wr_data;

  wilk_conv_seq #(.NCH(NCH), .DEPTH(DEPTH), .CW(CW), .BCW(BCW), .RAM_WORDS(RW)) dut (
    .clk(clk), .rst_n(rst_n), .start_conv(start_conv), .ramp_end(ramp_end),
    .gain_sel(gain_sel), .hit_map(hit_map), .col_bcid(col_bcid), .chip_id(chip_id),
    .ramp_run(ramp_run), .ramp_time(ramp_time), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .conv_done(conv_done), .no_trig(no_trig), .ram_full(ram_full));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int fq [DEPTH][NCH];
  int ft [DEPTH][NCH];
  logic [NCH-1:0] gv [DEPTH];
  bit extra_en = 1'b0, finished = 1'b0;
  int hcols[$];
  int cidx = -1, k = 0, exp_addr = 0, nwr = 0;
  logic pr_run = 1'b0, pr_time = 1'b0;
  logic [DW-1:0] expq[$];
  string expr[$];

  function automatic int capv(int f);
    return (f <= MAXV) ? f : MAXV;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // comparator and gain model, driven away from the active edge
  always @(negedge clk) begin
    if (ramp_run && rst_n) begin
      if (!pr_run) begin k = 0; cidx++; end
      else if (ramp_time != pr_time) k = 0;
      else k++;
      if (cidx >= 0 && cidx < hcols.size()) begin
        for (int i = 0; i < NCH; i++) begin
          int f;
          f = ramp_time ? ft[hcols[cidx]][i] : fq[hcols[cidx]][i];
          ramp_end[i] = (k == f) || (k >= f + 3);
        end
        if (!ramp_time && k == 0) gain_sel = gv[hcols[cidx]];
        else if (!ramp_time && k == 1) gain_sel = ~gv[hcols[cidx]];
      end
      st_extra = extra_en && (k == 5);
    end else begin
      ramp_end = '0;
      st_extra = 1'b0;
    end
    pr_run = ramp_run;
    pr_time = ramp_time;
  end

  // write monitor
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      nwr++;
      if (expq.size() == 0) check(1'b0, "R9 unexpected write", int'(wr_addr), -1);
      else begin
        logic [DW-1:0] e;
        string r;
        e = expq.pop_front();
        r = expr.pop_front();
        check(wr_data == e, r, int'(wr_data), int'(e));
      end
      check(int'(wr_addr) == exp_addr, "R9 address", int'(wr_addr), exp_addr);
      exp_addr++;
    end
  end

  task automatic build(output int total);
    int a = 0;
    expq.delete(); expr.delete(); hcols.delete();
    for (int c = 0; c < DEPTH; c++) begin
      if (|hit_map[c*NCH +: NCH]) begin
        hcols.push_back(c);
        for (int i = 0; i < NCH; i++) begin
          logic [DW-1:0] w;
          w = '0;
          w[2*CW+1] = hit_map[c*NCH+i];
          w[2*CW] = gv[c][i];
          w[2*CW-1:CW] = CW'(capv(fq[c][i]));
          w[CW-1:0] = CW'(capv(ft[c][i]));
          if (a < RW) begin
            expq.push_back(w);
            if (fq[c][i] > MAXV || ft[c][i] > MAXV) expr.push_back("R5 R6 R7 full-scale word");
            else expr.push_back("R3 R4 R6 R7 channel word");
          end
          a++;
        end
        if (a < RW) begin
          expq.push_back(DW'({chip_id, col_bcid[c*BCW +: BCW], 2'(c)}));
          expr.push_back("R2 R8 trailer");
        end
        a++;
      end
    end
    total = a;
  endtask

  task automatic randomize_event(int hit_pct);
    for (int c = 0; c < DEPTH; c++) begin
      for (int i = 0; i < NCH; i++) begin
        hit_map[c*NCH+i] = (($urandom % 100) < hit_pct);
        fq[c][i] = $urandom % (MAXV + 5);
        ft[c][i] = $urandom % (MAXV + 5);
      end
      gv[c] = NCH'($urandom);
      col_bcid[c*BCW +: BCW] = BCW'($urandom);
    end
    chip_id = 8'($urandom);
  endtask

  task automatic run_event(bit ext);
    int total, expw;
    build(total);
    expw = (total < RW) ? total : RW;
    extra_en = ext; cidx = -1; exp_addr = 0; nwr = 0;
    @(negedge clk); st_task = 1'b1;
    @(negedge clk); st_task = 1'b0;
    while (!conv_done) @(negedge clk);
    check(no_trig == (total == 0), "R10 no_trig", int'(no_trig), int'(total == 0));
    check(ram_full == (total >= RW), "R9 ram_full", int'(ram_full), int'(total >= RW));
    if (ext) check(nwr == expw, "R11 write count with start during run", nwr, expw);
    else check(nwr == expw, "R9 write count", nwr, expw);
    @(negedge clk);
    check(!conv_done, "R10 done lasts one cycle", int'(conv_done), 0);
    extra_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ramp_run && !ramp_time, "R1 ramp idle", int'(ramp_run), 0);
    check(!wr_en, "R1 no write", int'(wr_en), 0);
    check(!conv_done && !no_trig && !ram_full, "R1 flags clear",
          int'({conv_done, no_trig, ram_full}), 0);

    // empty hit map
    randomize_event(0);
    hit_map = '0;
    run_event(1'b0);

    // single column, directed comparator corners
    randomize_event(0);
    hit_map = '0;
    hit_map[2*NCH +: NCH] = 4'b0101;
    fq[2][0] = 0;        fq[2][1] = MAXV;     fq[2][2] = MAXV + 4; fq[2][3] = 7;
    ft[2][0] = MAXV;     ft[2][1] = 3;        ft[2][2] = 0;        ft[2][3] = MAXV + 2;
    gv[2] = 4'b1010;
    run_event(1'b0);

    // start pulses during a run
    randomize_event(50);
    hit_map[0] = 1'b1;
    run_event(1'b1);

    // every column hit: overruns the RAM
    randomize_event(100);
    run_event(1'b0);

    // random mix
    for (int e = 0; e < 8; e++) begin
      randomize_event(25 + 10 * e);
      run_event(e == 3);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule